// File: doc/BRIEF.md
# Early-Terminating Iterative Multiplier

This block multiplies two 32-bit integers over several clock cycles. Each internal cycle it retires one 8-bit slice of the multiplier operand, starting from the least significant slice. It stops as soon as the multiplier bits it has not yet consumed carry no information beyond sign or zero extension. Short operands therefore finish in fewer cycles than wide ones.

Six operations are selected by a 3-bit code. The short forms are a 32-bit multiply and a 32-bit multiply-accumulate. The long forms are a 64-bit multiply and a 64-bit multiply-accumulate, each available signed or unsigned. An accumulate adds one extra cycle, spent on the low half. A long form adds one extra cycle, spent on the high half. The block reports how many internal cycles the operation took, and pulses done when the result is ready.

A command is accepted only while the unit is idle. A start pulse that arrives during a run is dropped.

Top module: `mul_early_term`

## Requirements
- R1: The slice count m is the smallest k in 1..3 for which mplier bits [31:8k] are all zero, or all one in signed mode. When no such k exists, m is 4.
- R2: The operation code is op[0] = accumulate, op[1] = long, op[2] = signed. op[2] applies only to the long forms; short forms always use the signed test. The cycle count is m + op[0] + op[1]. It is presented on `cycles_o` from the clock edge that accepts the start.
- R3: If start is sampled at edge E, `done_o` is high for exactly one cycle, following edge E + `cycles_o`.
- R4: A short multiply (op 000) returns the low 32 bits of mcand*mplier in result[31:0]. result[63:32] is zero.
- R5: A short multiply-accumulate (op 001) returns the low 32 bits of mcand*mplier + acc[31:0]. result[63:32] is zero.
- R6: An unsigned long form (op 010, 011) returns the 64-bit unsigned product, plus acc for op 011, modulo 2^64.
- R7: A signed long form (op 110, 111) returns the 64-bit two's-complement product, plus acc for op 111, modulo 2^64.
- R8: Unsigned long forms stop early only on all-zero upper bits. All-one upper bits run the full four slices.
- R9: A start pulse received while busy has no effect on the result, the cycle count or the done timing.
- R10: After done, `result_o` and `cycles_o` hold their values until the next accepted start.
- R11: After reset, `done_o`, `result_o` and `cycles_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted when idle |
| op_i | input | 3 | Operation code: {signed, long, accumulate} |
| mcand_i | input | 32 | Multiplicand |
| mplier_i | input | 32 | Multiplier, consumed 8 bits per cycle |
| acc_i | input | 64 | Accumulate addend (short forms use bits 31:0) |
| result_o | output | 64 | Result |
| done_o | output | 1 | One-cycle completion pulse |
| cycles_o | output | 3 | Internal cycles used by the current or last operation |

## Verification
Several properties are checked on every cycle:
- the done pulse lasts a single cycle;
- the number of busy cycles matches the reported count;
- each result equals a reference product formed from the operands captured at acceptance;
- the high half is zero for short forms;
- a start during a run leaves the count untouched;
- the outputs hold steady while idle.

Other behaviours only the directed scenarios can show. These are:
- that m follows the slice rule for chosen operand patterns, such as all-ones upper bits with bit 7 clear;
- that the unsigned forms refuse the all-ones shortcut;
- that a dropped start leaves the run's result intact.

// File: rtl/mul_et_pkg.sv
`timescale 1ns/1ps
package mul_et_pkg;
  localparam int OP_ACC  = 0;
  localparam int OP_LONG = 1;
  localparam int OP_SGN  = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ITER,
    ST_ACC_LO,
    ST_ACC_HI
  } mul_st_e;
endpackage

// File: rtl/mul_stop_detect.sv
`timescale 1ns/1ps
module mul_stop_detect #(
  parameter int WIDTH  = 32,
  parameter int SLICE  = 8,
  parameter int NSLICE = WIDTH / SLICE,
  parameter int CW     = $clog2(NSLICE + 3)
) (
  input  logic [WIDTH-1:0] mplier_i,
  input  logic             sgn_i,
  output logic [CW-1:0]    iters_o
);
  logic [NSLICE-1:1] stop;

  // stop[k]: everything above slice k-1 is pure extension
  for (genvar k = 1; k < NSLICE; k++) begin : g_stop
    assign stop[k] = ~(|mplier_i[WIDTH-1:k*SLICE]) |
                     (sgn_i & (&mplier_i[WIDTH-1:k*SLICE]));
  end

  always_comb begin
    iters_o = CW'(NSLICE);
    for (int k = NSLICE - 1; k >= 1; k--) begin
      if (stop[k]) iters_o = CW'(k);
    end
  end
endmodule

// File: rtl/mul_partial.sv
`timescale 1ns/1ps
module mul_partial #(
  parameter int PW    = 64,
  parameter int SLICE = 8
) (
  input  logic [PW-1:0]    mcand_i,
  input  logic [SLICE-1:0] slice_i,
  input  logic             ext_i,
  output logic [PW-1:0]    pp_o
);
  logic signed [SLICE:0]  slice_s;
  logic signed [PW-1:0]   slice_x;
  logic signed [PW-1:0]   mcand_s;

  // ext_i gives the slice a weight of -2^SLICE when upper bits were all ones
  assign slice_s = {ext_i, slice_i};
  assign slice_x = PW'(slice_s);
  assign mcand_s = mcand_i;
  assign pp_o    = mcand_s * slice_x;
endmodule

// File: rtl/mul_half_add.sv
`timescale 1ns/1ps
module mul_half_add #(
  parameter int HW = 32
) (
  input  logic [HW-1:0] x_i,
  input  logic [HW-1:0] y_i,
  input  logic          cin_i,
  output logic [HW-1:0] sum_o,
  output logic          cout_o
);
  assign {cout_o, sum_o} = {1'b0, x_i} + {1'b0, y_i} + {{HW{1'b0}}, cin_i};
endmodule

// File: rtl/mul_early_term.sv
`timescale 1ns/1ps
module mul_early_term #(
  parameter int WIDTH = 32,
  parameter int SLICE = 8,
  localparam int PW     = 2 * WIDTH,
  localparam int NSLICE = WIDTH / SLICE,
  localparam int CW     = $clog2(NSLICE + 3)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [2:0]       op_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic [WIDTH-1:0] mplier_i,
  input  logic [PW-1:0]    acc_i,
  output logic [PW-1:0]    result_o,
  output logic             done_o,
  output logic [CW-1:0]    cycles_o
);
  import mul_et_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  // state
  mul_st_e          state_q,  state_d;
  logic [PW-1:0]    mcand_q,  mcand_d;
  logic [WIDTH-1:0] mplier_q, mplier_d;
  logic [CW-1:0]    left_q,   left_d;
  logic             negtop_q, negtop_d;
  logic [PW-1:0]    acc_q,    acc_d;
  logic             long_q,   long_d;
  logic             accf_q,   accf_d;
  logic             carry_q,  carry_d;
  logic [PW-1:0]    prod_q,   prod_d;
  logic [CW-1:0]    cycles_q, cycles_d;
  logic             done_q,   done_d;

  logic             accept;
  logic             upd_en;
  logic             sgn_in;
  logic [CW-1:0]    iters;
  logic [PW-1:0]    pp;
  logic             pp_ext;
  logic [WIDTH-1:0] add_x, add_y, add_sum;
  logic             add_cin, add_cout;

  assign accept = start_i && (state_q == ST_IDLE);
  assign upd_en = accept || (state_q != ST_IDLE);
  assign sgn_in = op_i[OP_SGN] | ~op_i[OP_LONG];
  assign pp_ext = negtop_q && (left_q == CW'(1));

  mul_stop_detect #(
    .WIDTH (WIDTH),
    .SLICE (SLICE),
    .NSLICE(NSLICE),
    .CW    (CW)
  ) u_stop (
    .mplier_i(mplier_i),
    .sgn_i   (sgn_in),
    .iters_o (iters)
  );

  mul_partial #(
    .PW   (PW),
    .SLICE(SLICE)
  ) u_pp (
    .mcand_i(mcand_q),
    .slice_i(mplier_q[SLICE-1:0]),
    .ext_i  (pp_ext),
    .pp_o   (pp)
  );

  // one 32-bit adder serves both tail cycles
  always_comb begin
    if (state_q == ST_ACC_HI) begin
      add_x   = prod_q[PW-1:WIDTH];
      add_y   = accf_q ? acc_q[PW-1:WIDTH] : '0;
      add_cin = carry_q;
    end else begin
      add_x   = prod_q[WIDTH-1:0];
      add_y   = acc_q[WIDTH-1:0];
      add_cin = 1'b0;
    end
  end

  mul_half_add #(
    .HW(WIDTH)
  ) u_add (
    .x_i   (add_x),
    .y_i   (add_y),
    .cin_i (add_cin),
    .sum_o (add_sum),
    .cout_o(add_cout)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    mcand_d  = mcand_q;
    mplier_d = mplier_q;
    left_d   = left_q;
    negtop_d = negtop_q;
    acc_d    = acc_q;
    long_d   = long_q;
    accf_d   = accf_q;
    carry_d  = carry_q;
    prod_d   = prod_q;
    cycles_d = cycles_q;
    done_d   = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          mcand_d  = sgn_in ? {{WIDTH{mcand_i[WIDTH-1]}}, mcand_i}
                            : {{WIDTH{1'b0}}, mcand_i};
          mplier_d = mplier_i;
          left_d   = iters;
          negtop_d = sgn_in & mplier_i[WIDTH-1];
          acc_d    = acc_i;
          long_d   = op_i[OP_LONG];
          accf_d   = op_i[OP_ACC];
          carry_d  = 1'b0;
          prod_d   = '0;
          cycles_d = iters + {{(CW-1){1'b0}}, op_i[OP_ACC]}
                           + {{(CW-1){1'b0}}, op_i[OP_LONG]};
          state_d  = ST_ITER;
        end
      end
      ST_ITER: begin
        prod_d   = prod_q + pp;
        mcand_d  = mcand_q << SLICE;
        mplier_d = mplier_q >> SLICE;
        left_d   = left_q - CW'(1);
        if (left_q == CW'(1)) begin
          if (accf_q)      state_d = ST_ACC_LO;
          else if (long_q) state_d = ST_ACC_HI;
          else begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      ST_ACC_LO: begin
        prod_d[WIDTH-1:0] = add_sum;
        carry_d           = add_cout;
        if (long_q) state_d = ST_ACC_HI;
        else begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      ST_ACC_HI: begin
        prod_d[PW-1:WIDTH] = add_sum;
        state_d            = ST_IDLE;
        done_d             = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q  <= ST_IDLE;
      mcand_q  <= '0;
      mplier_q <= '0;
      left_q   <= '0;
      negtop_q <= 1'b0;
      acc_q    <= '0;
      long_q   <= 1'b0;
      accf_q   <= 1'b0;
      carry_q  <= 1'b0;
      prod_q   <= '0;
      cycles_q <= '0;
    end else if (upd_en) begin
      state_q  <= state_d;
      mcand_q  <= mcand_d;
      mplier_q <= mplier_d;
      left_q   <= left_d;
      negtop_q <= negtop_d;
      acc_q    <= acc_d;
      long_q   <= long_d;
      accf_q   <= accf_d;
      carry_q  <= carry_d;
      prod_q   <= prod_d;
      cycles_q <= cycles_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) done_q <= 1'b0;
    else         done_q <= done_d;
  end

  assign result_o = long_q ? prod_q : {{WIDTH{1'b0}}, prod_q[WIDTH-1:0]};
  assign done_o   = done_q;
  assign cycles_o = cycles_q;
endmodule

// File: rtl/mul_early_term_chk.sv
`timescale 1ns/1ps
module mul_early_term_chk #(
  parameter int WIDTH = 32,
  parameter int SLICE = 8,
  localparam int PW     = 2 * WIDTH,
  localparam int NSLICE = WIDTH / SLICE,
  localparam int CW     = $clog2(NSLICE + 3)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             idle_i,
  input logic             start_i,
  input logic [2:0]       op_i,
  input logic [WIDTH-1:0] mcand_i,
  input logic [WIDTH-1:0] mplier_i,
  input logic [PW-1:0]    acc_i,
  input logic [PW-1:0]    result_o,
  input logic             done_o,
  input logic [CW-1:0]    cycles_o
);
  logic [2:0]       op_c;
  logic [WIDTH-1:0] a_c, b_c;
  logic [PW-1:0]    acc_c;
  logic [CW+1:0]    cnt_q;
  logic [PW-1:0]    ref_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_c  <= '0;
      a_c   <= '0;
      b_c   <= '0;
      acc_c <= '0;
      cnt_q <= '0;
    end else if (start_i && idle_i) begin
      op_c  <= op_i;
      a_c   <= mcand_i;
      b_c   <= mplier_i;
      acc_c <= acc_i;
      cnt_q <= '0;
    end else if (!idle_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    logic          sg;
    logic [PW-1:0] ax, bx, p;
    sg = op_c[2] | ~op_c[1];
    ax = sg ? {{WIDTH{a_c[WIDTH-1]}}, a_c} : {{WIDTH{1'b0}}, a_c};
    bx = sg ? {{WIDTH{b_c[WIDTH-1]}}, b_c} : {{WIDTH{1'b0}}, b_c};
    p  = ax * bx;
    if (op_c[1]) ref_val = p + (op_c[0] ? acc_c : '0);
    else         ref_val = {{WIDTH{1'b0}},
                            p[WIDTH-1:0] + (op_c[0] ? acc_c[WIDTH-1:0] : '0)};
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R3
  AST_CYCLE_TALLY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cnt_q == {2'b00, cycles_o})); // R2
  AST_SHORT_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !op_c[1]) |-> (result_o[PW-1:WIDTH] == '0)); // R4
  AST_PRODUCT_OK: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (result_o == ref_val)); // R7
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !idle_i) |=> $stable(cycles_o)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_i && !start_i) |=> ($stable(result_o) && $stable(cycles_o))); // R10
  AST_SLICE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cycles_o >= CW'(1) && cycles_o <= CW'(NSLICE + 2))); // R1
endmodule

bind mul_early_term mul_early_term_chk #(
  .WIDTH(WIDTH),
  .SLICE(SLICE)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_ns),
  .idle_i  (state_q == mul_et_pkg::ST_IDLE),
  .start_i (start_i),
  .op_i    (op_i),
  .mcand_i (mcand_i),
  .mplier_i(mplier_i),
  .acc_i   (acc_i),
  .result_o(result_o),
  .done_o  (done_o),
  .cycles_o(cycles_o)
);

// File: tb/tb_mul_early_term.sv
`timescale 1ns/1ps
module tb_mul_early_term;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [2:0]  op_i;
  logic [31:0] mcand_i, mplier_i;
  logic [63:0] acc_i;
  logic [63:0] result_o;
  logic        done_o;
  logic [2:0]  cycles_o;

  int n_chk  = 0;
  int n_fail = 0;

  mul_early_term dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .op_i    (op_i),
    .mcand_i (mcand_i),
    .mplier_i(mplier_i),
    .acc_i   (acc_i),
    .result_o(result_o),
    .done_o  (done_o),
    .cycles_o(cycles_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #500000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    summary();
  end

  function automatic int exp_m(input logic [31:0] b, input bit sg);
    int m = 4;
    for (int k = 3; k >= 1; k--) begin
      logic [63:0] up, ones;
      up   = {32'b0, b} >> (8 * k);
      ones = (64'd1 << (32 - 8 * k)) - 64'd1;
      if (up == 64'd0 || (sg && up == ones)) m = k;
    end
    return m;
  endfunction

  function automatic logic [63:0] exp_res(input logic [2:0] op,
      input logic [31:0] a, input logic [31:0] b, input logic [63:0] acc);
    bit          sg = op[2] | ~op[1];
    logic [63:0] ax = sg ? {{32{a[31]}}, a} : {32'b0, a};
    logic [63:0] bx = sg ? {{32{b[31]}}, b} : {32'b0, b};
    logic [63:0] p  = ax * bx;
    logic [31:0] lo;
    if (op[1]) return p + (op[0] ? acc : 64'd0);
    lo = p[31:0] + (op[0] ? acc[31:0] : 32'd0);
    return {32'b0, lo};
  endfunction

  // poke > 0: raise a competing start after that many cycles of waiting
  task automatic run_op(input logic [2:0] op, input logic [31:0] a,
      input logic [31:0] b, input logic [63:0] acc, input string ctag,
      input string rtag, input int poke);
    int          ec  = exp_m(b, op[2] | ~op[1]) + int'(op[0]) + int'(op[1]);
    logic [63:0] er  = exp_res(op, a, b, acc);
    int          got = 0;
    @(negedge clk);
    start_i = 1'b1; op_i = op; mcand_i = a; mplier_i = b; acc_i = acc;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 1; i <= 30 && got == 0; i++) begin
      @(negedge clk);
      if (done_o) got = i;
      if (i == poke) begin
        start_i = 1'b1; op_i = 3'b000; mcand_i = 32'd3; mplier_i = 32'd5;
        acc_i = 64'd0;
      end else begin
        start_i = 1'b0;
      end
    end
    chk(got == ec, "R3 done latency", 64'(got), 64'(ec));
    chk(cycles_o == 3'(ec), {ctag, " R2 cycle count"}, 64'(cycles_o), 64'(ec));
    chk(result_o == er, rtag, result_o, er);
    @(negedge clk);
    chk(done_o == 1'b0, "R3 done width", 64'(done_o), 64'd0);
  endtask

  task automatic t_reset();
    chk(done_o == 1'b0 && result_o == 64'd0 && cycles_o == 3'd0,
        "R11 reset state", result_o | 64'(cycles_o) | 64'(done_o), 64'd0);
  endtask

  task automatic t_mul();
    run_op(3'b000, 32'h1234_5678, 32'h0000_005A, 64'd0, "R1", "R4", 0);
    run_op(3'b000, 32'h1234_5678, 32'hFFFF_FF05, 64'd0, "R1", "R4", 0);
    run_op(3'b000, 32'hDEAD_BEEF, 32'h0000_1234, 64'd0, "R1", "R4", 0);
    run_op(3'b000, 32'h0BAD_F00D, 32'hFFFF_8000, 64'd0, "R1", "R4", 0);
    run_op(3'b000, 32'h7654_3210, 32'h00AB_CDEF, 64'd0, "R1", "R4", 0);
    run_op(3'b000, 32'hFFFF_FFFF, 32'h8000_0001, 64'd0, "R1", "R4", 0);
  endtask

  task automatic t_mla();
    run_op(3'b001, 32'h0000_1000, 32'h0000_0011, 64'hAAAA_5555_FFFF_FFF0,
           "R1", "R5", 0);
    run_op(3'b001, 32'h8765_4321, 32'h1357_9BDF, 64'h0000_0000_1234_5678,
           "R1", "R5", 0);
  endtask

  task automatic t_unsigned();
    run_op(3'b010, 32'hFFFF_FFFF, 32'h0000_00FF, 64'd0, "R1", "R6", 0);
    run_op(3'b010, 32'hFFFF_FFFF, 32'hFFFF_FF05, 64'd0, "R8", "R6", 0);
    run_op(3'b011, 32'h8000_0000, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
           "R8", "R6", 0);
    run_op(3'b011, 32'h0001_0000, 32'h0000_7F00, 64'h0000_0001_FFFF_FFFF,
           "R1", "R6", 0);
  endtask

  task automatic t_signed();
    run_op(3'b110, 32'hFFFF_FFF6, 32'hFFFF_FF05, 64'd0, "R1", "R7", 0);
    run_op(3'b110, 32'h8000_0000, 32'h8000_0000, 64'd0, "R1", "R7", 0);
    run_op(3'b111, 32'h1234_5678, 32'hFFFF_8001, 64'h8000_0000_0000_0001,
           "R1", "R7", 0);
  endtask

  task automatic t_busy();
    run_op(3'b111, 32'hCAFE_BABE, 32'h8000_0001, 64'h0123_4567_89AB_CDEF,
           "R9", "R9 result", 2);
  endtask

  task automatic t_hold();
    logic [63:0] r;
    logic [2:0]  c;
    run_op(3'b011, 32'hFEDC_BA98, 32'h0F0F_0F0F, 64'd7, "R1", "R6", 0);
    r = result_o;
    c = cycles_o;
    repeat (5) @(negedge clk);
    chk(result_o == r, "R10 result held", result_o, r);
    chk(cycles_o == c, "R10 cycles held", 64'(cycles_o), 64'(c));
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; op_i = 3'b000;
    mcand_i = '0; mplier_i = '0; acc_i = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_mul();
    t_mla();
    t_unsigned();
    t_signed();
    t_busy();
    t_hold();
    summary();
  end
endmodule